// File: doc/BRIEF.md
# Small-Page NAND Flash Device Command Model

This block is a synthesizable model of the device side of a small-page NAND flash part. It is meant to sit in a verification environment as the target of a flash controller. The pins are sampled synchronously. A write cycle is one clock with `wrStb` high and `chipEnN` low. That cycle carries a command, an address byte or a data byte, and the two latch-enable pins decide which. A read cycle is one clock with `rdStb` high, and the byte it returns appears on `busOut` after the next rising edge.

The array holds `BLK_COUNT` blocks. Each block has `PG_PER_BLK` pages, and each page has 512 main bytes and 16 spare bytes. A real part has 32 pages per block. The default here is smaller so that the model stays compact.

A pointer command picks which part of the page a column byte refers to. Programming goes through a page buffer and can only clear bits. Erase returns a whole block to ones. While the device is busy, `ready` is low. The busy windows are parameters given in clock cycles. Program and erase each last at least as long as their internal byte-per-cycle walk of the array.

A status register reports three things: write protection, ready state and the fail flag of the last program or erase. A two-byte identifier can also be read back.

Top module: `nand_sp_model`

## Requirements
- R1: After reset, `ready` is 1, `busOut` is 00h, the pointer selects the lower half and every array byte reads FFh.
- R2: Pointer 00h maps column byte c to page offset c. Pointer 01h maps it to offset 256+c.
- R3: Pointer 50h maps column byte c to offset 512+c[3:0]. Bits c[7:4] are ignored.
- R4: A read starts with a pointer command and four address cycles: column, page index, then two unused bytes. `ready` then stays low for exactly `T_READ` cycles. After that, each read cycle returns the next byte from the start offset up to offset 527, and read cycles past offset 527 return FFh.
- R5: After a read or program that was set up with pointer 01h leaves its busy window, the pointer returns to the lower half. Pointers 00h and 50h stay selected across operations until another pointer command arrives.
- R6: A program is 80h, four address cycles, data bytes and then 10h. It holds `ready` low for max(`T_PROG`, 528) cycles. Each written offset becomes old AND data. Offsets that were not written keep their value, and data bytes past offset 527 are dropped.
- R7: An erase is 60h, three address cycles (the first carries the page index) and then D0h. It holds `ready` low for max(`T_ERASE`, bytes per block) cycles and sets every byte of the addressed block to FFh. Other blocks are unchanged.
- R8: After 70h, every read cycle returns the status byte, including while busy. Bit 7 is 1 when the part is not write protected. Bit 6 is 1 when ready and 0 when busy. Bit 0 is 1 when the last program or erase was refused. Bits 5 to 1 read 0.
- R9: After 90h and one address cycle, the first read returns 20h, the second 76h, and later reads return FFh.
- R10: If `wrProtN` is 0 at the 10h or D0h confirm, the operation is refused. `ready` stays 1, the array is unchanged and status bit 0 becomes 1. An accepted program or erase clears bit 0.
- R11: An unknown command byte changes nothing. While busy, every command except 70h is ignored.
- R12: Write cycles with `chipEnN` high, and write cycles with both latch enables high, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chipEnN | input | 1 | Active-low chip enable |
| cmdLatch | input | 1 | Marks a write cycle as a command |
| addrLatch | input | 1 | Marks a write cycle as an address byte |
| wrStb | input | 1 | One-cycle write strobe |
| rdStb | input | 1 | One-cycle read strobe |
| wrProtN | input | 1 | Active-low write protect |
| busIn | input | 8 | Command, address or data byte |
| busOut | output | 8 | Byte returned by the last read cycle |
| ready | output | 1 | 1 when ready, 0 when busy |

## Verification
A status read can land on the same edge on which a busy window closes, so the ready bit in the returned byte and the `ready` pin both change around that edge. The bench triggers this by polling status back to back through an entire program window. For each poll it records the `ready` pin at the sampling point just before the read, and requires the returned bit 6 to equal that value. The same poll loop also sends a pointer command during busy. A status read after busy then proves that the command was ignored, because the output did not switch back to array data.

// File: rtl/nand_sp_pkg.sv
package nand_sp_pkg;

  localparam int PAGE_MAIN  = 512;
  localparam int PAGE_SPARE = 16;
  localparam int PAGE_BYTES = PAGE_MAIN + PAGE_SPARE;

  localparam logic [7:0] CMD_PTR_LO   = 8'h00;
  localparam logic [7:0] CMD_PTR_HI   = 8'h01;
  localparam logic [7:0] CMD_PTR_SP   = 8'h50;
  localparam logic [7:0] CMD_PROG     = 8'h80;
  localparam logic [7:0] CMD_PROG_GO  = 8'h10;
  localparam logic [7:0] CMD_ERASE    = 8'h60;
  localparam logic [7:0] CMD_ERASE_GO = 8'hD0;
  localparam logic [7:0] CMD_STATUS   = 8'h70;
  localparam logic [7:0] CMD_SIG      = 8'h90;

  localparam logic [7:0] SIG_MAKER  = 8'h20;
  localparam logic [7:0] SIG_DEVICE = 8'h76;

  typedef enum logic [1:0] {AREA_LO, AREA_HI, AREA_SP} area_e;

  typedef enum logic [2:0] {SRC_MEM, SRC_STATUS, SRC_MAKER, SRC_DEVICE, SRC_ONES} outSrc_e;

  typedef struct packed {
    logic    bufClear;
    logic    bufWrite;
    logic    progByte;
    logic    eraseByte;
    logic    outLoad;
    outSrc_e outSrc;
  } dpStrobe_t;

endpackage

// File: rtl/nand_sp_datapath.sv
module nand_sp_datapath
  import nand_sp_pkg::*;
#(
  parameter int MEM_BYTES = 2112,
  parameter int MEM_AW    = 12,
  parameter int COL_W     = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [MEM_AW-1:0] memIdx,
  input  logic [COL_W-1:0]  bufCol,
  input  logic [7:0]        busIn,
  input  logic [7:0]        statusByte,
  output logic [7:0]        busOut
);

  logic [7:0]            mem      [MEM_BYTES];
  logic [7:0]            bufData  [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] bufValid;
  logic [7:0]            progVal;

  assign progVal = bufValid[bufCol] ? bufData[bufCol] : 8'hFF;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
      bufValid <= '0;
      busOut   <= 8'h00;
    end else begin
      if (strb.bufClear) bufValid <= '0;
      if (strb.bufWrite) begin
        bufData[bufCol]  <= busIn;
        bufValid[bufCol] <= 1'b1;
      end
      if (strb.progByte)  mem[memIdx] <= mem[memIdx] & progVal;
      if (strb.eraseByte) mem[memIdx] <= 8'hFF;
      if (strb.outLoad) begin
        case (strb.outSrc)
          SRC_MEM:    busOut <= mem[memIdx];
          SRC_STATUS: busOut <= statusByte;
          SRC_MAKER:  busOut <= SIG_MAKER;
          SRC_DEVICE: busOut <= SIG_DEVICE;
          default:    busOut <= 8'hFF;
        endcase
      end
    end
  end

  AST_AND_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    strb.progByte |=> ((mem[$past(memIdx)] & ~$past(mem[memIdx])) == 8'h00)); // R6

  AST_ERASE_ONES: assert property (@(posedge clk) disable iff (!rstN)
    strb.eraseByte |=> (mem[$past(memIdx)] == 8'hFF)); // R7

endmodule

// File: rtl/nand_sp_ctrl.sv
module nand_sp_ctrl
  import nand_sp_pkg::*;
#(
  parameter int BLK_COUNT  = 2,
  parameter int PG_PER_BLK = 2,
  parameter int T_READ     = 8,
  parameter int T_PROG     = 600,
  parameter int T_ERASE    = 1200,
  parameter int MEM_AW     = 12,
  parameter int COL_W      = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipEnN,
  input  logic              cmdLatch,
  input  logic              addrLatch,
  input  logic              wrStb,
  input  logic              rdStb,
  input  logic              wrProtN,
  input  logic [7:0]        busIn,
  output dpStrobe_t         strb,
  output logic [MEM_AW-1:0] memIdx,
  output logic [COL_W-1:0]  bufCol,
  output logic [7:0]        statusByte,
  output logic              ready
);

  localparam int PAGES     = BLK_COUNT * PG_PER_BLK;
  localparam int PIDX_W    = $clog2(PAGES);
  localparam int PG_W      = $clog2(PG_PER_BLK);
  localparam int BLK_BYTES = PG_PER_BLK * PAGE_BYTES;
  localparam int PROG_EFF  = (T_PROG > PAGE_BYTES) ? T_PROG : PAGE_BYTES;
  localparam int ERASE_EFF = (T_ERASE > BLK_BYTES) ? T_ERASE : BLK_BYTES;
  localparam int T_MAX0    = (PROG_EFF > ERASE_EFF) ? PROG_EFF : ERASE_EFF;
  localparam int T_MAX     = (T_MAX0 > T_READ) ? T_MAX0 : T_READ;
  localparam int CNT_W     = $clog2(T_MAX + 1);

  localparam logic [CNT_W-1:0] READ_LAST  = CNT_W'(T_READ - 1);
  localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROG_EFF - 1);
  localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_EFF - 1);
  localparam logic [CNT_W-1:0] PAGE_CNT   = CNT_W'(PAGE_BYTES);
  localparam logic [CNT_W-1:0] BLK_CNT    = CNT_W'(BLK_BYTES);
  localparam logic [COL_W-1:0] COL_END    = COL_W'(PAGE_BYTES);

  typedef enum logic [3:0] {
    ST_IDLE, ST_RADDR, ST_RBUSY, ST_RDATA, ST_PADDR, ST_PDATA,
    ST_PBUSY, ST_EADDR, ST_EBUSY, ST_SADDR, ST_SDATA
  } state_e;

  state_e            state;
  area_e             ptr;
  logic [7:0]        colByte;
  logic [PIDX_W-1:0] row;
  logic [1:0]        addrIdx;
  logic [COL_W-1:0]  curCol;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        sigIdx;
  logic              fail, statMode, busy;
  logic              wrCyc, cmdCyc, addrCyc, dataCyc, rdCyc;
  logic [MEM_AW-1:0] pageBase, blkBase;

  assign wrCyc   = wrStb & ~chipEnN;
  assign cmdCyc  = wrCyc & cmdLatch & ~addrLatch;
  assign addrCyc = wrCyc & addrLatch & ~cmdLatch;
  assign dataCyc = wrCyc & ~addrLatch & ~cmdLatch;
  assign rdCyc   = rdStb & ~chipEnN;

  assign busy       = (state == ST_RBUSY) || (state == ST_PBUSY) || (state == ST_EBUSY);
  assign ready      = ~busy;
  assign statusByte = {wrProtN, ~busy, 5'b00000, fail};

  assign pageBase = MEM_AW'(row) * MEM_AW'(PAGE_BYTES);
  assign blkBase  = MEM_AW'(row[PIDX_W-1:PG_W]) * MEM_AW'(BLK_BYTES);

  function automatic logic [COL_W-1:0] startCol(area_e a, logic [7:0] c);
    case (a)
      AREA_HI: startCol = COL_W'(256) + COL_W'(c);
      AREA_SP: startCol = COL_W'(PAGE_MAIN) + COL_W'(c[3:0]);
      default: startCol = COL_W'(c);
    endcase
  endfunction

  always_comb begin
    strb   = '0;
    memIdx = '0;
    bufCol = curCol;
    case (state)
      ST_PDATA: if (dataCyc && curCol < COL_END) strb.bufWrite = 1'b1;
      ST_PBUSY: if (cnt < PAGE_CNT) begin
        strb.progByte = 1'b1;
        bufCol        = COL_W'(cnt);
        memIdx        = pageBase + MEM_AW'(cnt);
      end
      ST_EBUSY: if (cnt < BLK_CNT) begin
        strb.eraseByte = 1'b1;
        memIdx         = blkBase + MEM_AW'(cnt);
      end
      default: ;
    endcase
    if (cmdCyc && !busy && busIn == CMD_PROG) strb.bufClear = 1'b1;
    if (rdCyc) begin
      if (statMode) begin
        strb.outLoad = 1'b1;
        strb.outSrc  = SRC_STATUS;
      end else if (state == ST_RDATA) begin
        strb.outLoad = 1'b1;
        strb.outSrc  = (curCol < COL_END) ? SRC_MEM : SRC_ONES;
        memIdx       = pageBase + MEM_AW'(curCol);
      end else if (state == ST_SDATA) begin
        strb.outLoad = 1'b1;
        strb.outSrc  = (sigIdx == 2'd0) ? SRC_MAKER : (sigIdx == 2'd1) ? SRC_DEVICE : SRC_ONES;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      ptr      <= AREA_LO;
      colByte  <= '0;
      row      <= '0;
      addrIdx  <= '0;
      curCol   <= '0;
      cnt      <= '0;
      sigIdx   <= '0;
      fail     <= 1'b0;
      statMode <= 1'b0;
    end else begin
      if (cmdCyc && busIn == CMD_STATUS) statMode <= 1'b1;
      else if (cmdCyc && !busy) begin
        case (busIn)
          CMD_PTR_LO, CMD_PTR_HI, CMD_PTR_SP: begin
            ptr      <= (busIn == CMD_PTR_LO) ? AREA_LO : (busIn == CMD_PTR_HI) ? AREA_HI : AREA_SP;
            state    <= ST_RADDR;
            addrIdx  <= '0;
            statMode <= 1'b0;
          end
          CMD_PROG:  begin state <= ST_PADDR; addrIdx <= '0; statMode <= 1'b0; end
          CMD_ERASE: begin state <= ST_EADDR; addrIdx <= '0; statMode <= 1'b0; end
          CMD_SIG:   begin state <= ST_SADDR; statMode <= 1'b0; end
          CMD_PROG_GO: if (state == ST_PDATA) begin
            statMode <= 1'b0;
            fail     <= ~wrProtN;
            cnt      <= '0;
            state    <= wrProtN ? ST_PBUSY : ST_IDLE;
          end
          CMD_ERASE_GO: if (state == ST_EADDR && addrIdx == 2'd3) begin
            statMode <= 1'b0;
            fail     <= ~wrProtN;
            cnt      <= '0;
            state    <= wrProtN ? ST_EBUSY : ST_IDLE;
          end
          default: ;
        endcase
      end
      if (addrCyc && !busy) begin
        case (state)
          ST_RADDR, ST_PADDR: begin
            if (addrIdx == 2'd0) colByte <= busIn;
            if (addrIdx == 2'd1) row <= busIn[PIDX_W-1:0];
            if (addrIdx != 2'd3) addrIdx <= addrIdx + 2'd1;
            else if (state == ST_RADDR) begin
              state <= ST_RBUSY;
              cnt   <= '0;
            end else begin
              state  <= ST_PDATA;
              curCol <= startCol(ptr, colByte);
            end
          end
          ST_EADDR: begin
            if (addrIdx == 2'd0) row <= busIn[PIDX_W-1:0];
            if (addrIdx != 2'd3) addrIdx <= addrIdx + 2'd1;
          end
          ST_SADDR: begin state <= ST_SDATA; sigIdx <= '0; end
          default: ;
        endcase
      end
      if (dataCyc && state == ST_PDATA && curCol < COL_END) curCol <= curCol + 1'b1;
      if (rdCyc && !statMode) begin
        if (state == ST_RDATA && curCol < COL_END) curCol <= curCol + 1'b1;
        if (state == ST_SDATA && sigIdx != 2'd3) sigIdx <= sigIdx + 2'd1;
      end
      case (state)
        ST_RBUSY: if (cnt == READ_LAST) begin
          state  <= ST_RDATA;
          curCol <= startCol(ptr, colByte);
          if (ptr == AREA_HI) ptr <= AREA_LO;
        end else cnt <= cnt + 1'b1;
        ST_PBUSY: if (cnt == PROG_LAST) begin
          state <= ST_IDLE;
          if (ptr == AREA_HI) ptr <= AREA_LO;
        end else cnt <= cnt + 1'b1;
        ST_EBUSY: if (cnt == ERASE_LAST) state <= ST_IDLE;
          else cnt <= cnt + 1'b1;
        default: ;
      endcase
    end
  end

  AST_CONFIRM_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (cmdCyc && busIn == CMD_PROG_GO && state == ST_PDATA && wrProtN) |=> !ready); // R6

  AST_WP_REFUSE: assert property (@(posedge clk) disable iff (!rstN)
    (cmdCyc && !wrProtN && ((busIn == CMD_PROG_GO && state == ST_PDATA) ||
     (busIn == CMD_ERASE_GO && state == ST_EADDR && addrIdx == 2'd3))) |=> (ready && fail)); // R10

  AST_PTR_RETURN: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_PBUSY || state == ST_RBUSY) && $fell(busy) == 1'b0 && busy && $past(ptr) == AREA_HI && ptr == AREA_HI
     && ((state == ST_PBUSY && cnt == PROG_LAST) || (state == ST_RBUSY && cnt == READ_LAST))) |=> (ptr == AREA_LO)); // R5

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdCyc && busIn == CMD_ERASE) |=> (state != ST_EADDR)); // R11

endmodule

// File: rtl/nand_sp_model.sv
module nand_sp_model
  import nand_sp_pkg::*;
#(
  parameter int BLK_COUNT  = 2,
  parameter int PG_PER_BLK = 2,
  parameter int T_READ     = 8,
  parameter int T_PROG     = 600,
  parameter int T_ERASE    = 1200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       chipEnN,
  input  logic       cmdLatch,
  input  logic       addrLatch,
  input  logic       wrStb,
  input  logic       rdStb,
  input  logic       wrProtN,
  input  logic [7:0] busIn,
  output logic [7:0] busOut,
  output logic       ready
);

  localparam int MEM_BYTES = BLK_COUNT * PG_PER_BLK * PAGE_BYTES;
  localparam int MEM_AW    = $clog2(MEM_BYTES);
  localparam int COL_W     = $clog2(PAGE_BYTES);

  dpStrobe_t         strb;
  logic [MEM_AW-1:0] memIdx;
  logic [COL_W-1:0]  bufCol;
  logic [7:0]        statusByte;

  nand_sp_ctrl #(
    .BLK_COUNT(BLK_COUNT), .PG_PER_BLK(PG_PER_BLK), .T_READ(T_READ),
    .T_PROG(T_PROG), .T_ERASE(T_ERASE), .MEM_AW(MEM_AW), .COL_W(COL_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .chipEnN(chipEnN), .cmdLatch(cmdLatch),
    .addrLatch(addrLatch), .wrStb(wrStb), .rdStb(rdStb), .wrProtN(wrProtN),
    .busIn(busIn), .strb(strb), .memIdx(memIdx), .bufCol(bufCol),
    .statusByte(statusByte), .ready(ready)
  );

  nand_sp_datapath #(
    .MEM_BYTES(MEM_BYTES), .MEM_AW(MEM_AW), .COL_W(COL_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .memIdx(memIdx), .bufCol(bufCol),
    .busIn(busIn), .statusByte(statusByte), .busOut(busOut)
  );

endmodule

// File: tb/nand_sp_model_tb.sv
`timescale 1ns/1ps
module nand_sp_model_tb_top;

  localparam int NBLK = 2, NPG = 2, TRD = 8, TPG = 600, TER = 1200;
  localparam int PB = 528, NPAGES = NBLK * NPG;
  localparam int PROG_CYC = (TPG > PB) ? TPG : PB;
  localparam int ERASE_CYC = (TER > NPG * PB) ? TER : NPG * PB;

  logic clk = 1'b0, rstN = 1'b0, chipEnN = 1'b0, cmdLatch = 1'b0, addrLatch = 1'b0;
  logic wrStb = 1'b0, rdStb = 1'b0, wrProtN = 1'b1;
  logic [7:0] busIn = 8'h00, busOut;
  logic ready;

  int checks = 0, fails = 0;
  logic [7:0] model [NPAGES*PB];
  logic [7:0] pbuf [32];
  int mptr = 0;

  always #10 clk = ~clk;

  nand_sp_model #(.BLK_COUNT(NBLK), .PG_PER_BLK(NPG), .T_READ(TRD), .T_PROG(TPG), .T_ERASE(TER)) dut_i (
    .clk(clk), .rstN(rstN), .chipEnN(chipEnN), .cmdLatch(cmdLatch), .addrLatch(addrLatch),
    .wrStb(wrStb), .rdStb(rdStb), .wrProtN(wrProtN), .busIn(busIn), .busOut(busOut), .ready(ready));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wcyc(input logic c, input logic a, input logic [7:0] d);
    cmdLatch = c; addrLatch = a; busIn = d; wrStb = 1'b1;
    @(negedge clk);
    wrStb = 1'b0; cmdLatch = 1'b0; addrLatch = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] d); wcyc(1'b1, 1'b0, d); endtask
  task automatic adr(input logic [7:0] d); wcyc(1'b0, 1'b1, d); endtask
  task automatic din(input logic [7:0] d); wcyc(1'b0, 1'b0, d); endtask

  task automatic rd(output logic [7:0] v);
    rdStb = 1'b1;
    @(negedge clk);
    rdStb = 1'b0;
    v = busOut;
  endtask

  task automatic waitRdy(output int n);
    n = 0;
    while (!ready && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic sendRow(input int col, input int page);
    adr(8'(col)); adr(8'(page)); adr(8'h00); adr(8'h00);
  endtask

  function automatic int offOf(input int p, input int col);
    if (p == 1) return 256 + col;
    if (p == 2) return 512 + (col & 15);
    return col;
  endfunction

  function automatic logic [7:0] ptrCode(input int p);
    return (p == 1) ? 8'h01 : (p == 2) ? 8'h50 : 8'h00;
  endfunction

  // ptrSel: -1 keeps the current pointer, 0/1/2 issue 00h/01h/50h first
  task automatic progOp(input int ptrSel, input int col, input int page, input int len, output int n);
    int p;
    if (ptrSel >= 0) begin cmd(ptrCode(ptrSel)); mptr = ptrSel; end
    p = mptr;
    cmd(8'h80);
    sendRow(col, page);
    for (int i = 0; i < len; i++) din(pbuf[i]);
    cmd(8'h10);
    waitRdy(n);
    if (wrProtN) begin
      for (int i = 0; i < len; i++)
        if (offOf(p, col) + i < PB) model[page*PB + offOf(p, col) + i] &= pbuf[i];
      if (p == 1) mptr = 0;
    end
  endtask

  task automatic readAt(input int ptrSel, input int col, input int page, output logic [7:0] v, output int n);
    cmd(ptrCode(ptrSel));
    mptr = (ptrSel == 1) ? 0 : ptrSel;
    sendRow(col, page);
    waitRdy(n);
    rd(v);
  endtask

  task automatic readChk(input int page, input string req);
    logic [7:0] v;
    int n, bad, firstA, firstE;
    bad = 0; firstA = 0; firstE = 0;
    readAt(0, 0, page, v, n);
    for (int i = 0; i < PB; i++) begin
      if (i > 0) rd(v);
      if (v !== model[page*PB + i]) begin
        if (bad == 0) begin firstA = int'(v); firstE = int'(model[page*PB + i]); end
        bad++;
      end
    end
    check(bad == 0, req, firstA, firstE);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    int n, bad;
    logic r;
    void'($urandom(32'h1357));
    for (int i = 0; i < NPAGES*PB; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    check(ready === 1'b1, "R1 ready after reset", int'(ready), 1);
    check(busOut === 8'h00, "R1 busOut after reset", int'(busOut), 0);

    cmd(8'h90); adr(8'h00);
    rd(v); check(v === 8'h20, "R9 maker byte", int'(v), 'h20);
    rd(v); check(v === 8'h76, "R9 device byte", int'(v), 'h76);
    rd(v); check(v === 8'hFF, "R9 past end", int'(v), 'hFF);

    cmd(8'h70); rd(v);
    check(v === 8'hC0, "R8 idle status", int'(v), 'hC0);

    readAt(0, 40, 3, v, n);
    check(n == TRD, "R4 read busy length", n, TRD);
    check(v === 8'hFF, "R1 erased array", int'(v), 'hFF);

    // random partial programs in all three areas, checked against the bench model
    for (int it = 0; it < 6; it++) begin
      int a, pg, col, len;
      a = int'($urandom_range(0, 2)); pg = int'($urandom_range(0, NPAGES-1));
      col = int'($urandom_range(0, 255)); len = int'($urandom_range(1, 24));
      for (int i = 0; i < 32; i++) pbuf[i] = 8'($urandom);
      progOp(a, col, pg, len, n);
      check(n == PROG_CYC, "R6 program busy length", n, PROG_CYC);
      readChk(pg, "R6 random program readback (R2 R3)");
    end

    // directed: AND-only and partial program
    pbuf[0] = 8'hAA; pbuf[1] = 8'h55;
    progOp(0, 10, 0, 2, n);
    pbuf[0] = 8'h0F;
    progOp(0, 10, 0, 1, n);
    readAt(0, 9, 0, v, n);
    check(v === model[9], "R6 neighbour untouched", int'(v), int'(model[9]));
    rd(v); check(v === model[10], "R6 AND of two programs", int'(v), int'(model[10]));
    rd(v); check(v === model[11], "R4 streaming next byte", int'(v), int'(model[11]));

    // pointer 01h returns to the lower half after its program
    pbuf[0] = 8'h3C; progOp(1, 3, 0, 1, n);
    pbuf[0] = 8'h11; progOp(-1, 0, 0, 1, n);
    readAt(0, 0, 0, v, n);
    check(v === model[0] && model[0] === (8'h11 & model[0]), "R5 return to lower after program", int'(v), int'(model[0]));
    readAt(1, 3, 0, v, n);
    check(v === model[259], "R2 upper half offset", int'(v), int'(model[259]));
    pbuf[0] = 8'h22; progOp(-1, 1, 0, 1, n);
    readAt(0, 1, 0, v, n);
    check(v === model[1], "R5 return to lower after read", int'(v), int'(model[1]));

    // spare area: sticky pointer, masked column, end of page
    pbuf[0] = 8'h5A; progOp(2, 8'hF2, 1, 1, n);
    pbuf[0] = 8'hA5; progOp(-1, 5, 1, 1, n);
    pbuf[0] = 8'hC3; pbuf[1] = 8'h99; progOp(-1, 15, 1, 2, n);
    readAt(2, 8'h32, 1, v, n);
    check(v === model[PB + 514], "R3 spare offset with upper bits ignored", int'(v), int'(model[PB + 514]));
    rd(v); rd(v); rd(v);
    check(v === model[PB + 517], "R5 spare pointer sticky", int'(v), int'(model[PB + 517]));
    readAt(2, 8'h1F, 1, v, n);
    check(v === model[PB + 527], "R3 last spare byte", int'(v), int'(model[PB + 527]));
    rd(v); check(v === 8'hFF, "R4 read past page end", int'(v), 'hFF);

    // write protect refuses program
    wrProtN = 1'b0;
    pbuf[0] = 8'h00; progOp(0, 20, 0, 1, n);
    check(n == 0, "R10 refused program keeps ready", n, 0);
    cmd(8'h70); rd(v);
    check(v === 8'h41, "R10 status protected and failed (R8)", int'(v), 'h41);
    wrProtN = 1'b1;
    readAt(0, 20, 0, v, n);
    check(v === model[20], "R10 array unchanged", int'(v), int'(model[20]));

    // status polled through a busy window, pointer command during busy
    cmd(8'h00); sendRow(0, 2); waitRdy(n);
    mptr = 0;
    cmd(8'h80); sendRow(0, 2); din(8'h77); cmd(8'h10);
    cmd(8'h70);
    bad = 0; n = 0;
    cmd(8'h00);
    rd(v);
    check(v[6] === 1'b0, "R8 busy bit during program", int'(v), 'h80);
    while (n < 2000) begin
      r = ready;
      rd(v);
      if (v[6] !== r) bad++;
      n++;
      if (v[6] === 1'b1) break;
    end
    check(bad == 0 && v[6] === 1'b1, "R8 status bit tracks ready pin", bad, 0);
    model[2*PB] &= 8'h77;
    rd(v);
    check(v === 8'hC0, "R11 command during busy ignored", int'(v), 'hC0);
    cmd(8'h33); rd(v);
    check(v === 8'hC0, "R11 unknown command ignored", int'(v), 'hC0);
    chipEnN = 1'b1; cmd(8'h90); chipEnN = 1'b0; rd(v);
    check(v === 8'hC0, "R12 deselected write ignored", int'(v), 'hC0);
    wcyc(1'b1, 1'b1, 8'h90); rd(v);
    check(v === 8'hC0, "R12 both latches ignored", int'(v), 'hC0);
    readChk(2, "R6 program seen after busy poll");

    // erase block 0
    cmd(8'h60); adr(8'h00); adr(8'h00); adr(8'h00); cmd(8'hD0);
    waitRdy(n);
    check(n == ERASE_CYC, "R7 erase busy length", n, ERASE_CYC);
    cmd(8'h70); rd(v);
    check(v === 8'hC0, "R10 fail cleared by accepted erase", int'(v), 'hC0);
    for (int i = 0; i < 2*PB; i++) model[i] = 8'hFF;
    readChk(0, "R7 page 0 erased");
    readChk(1, "R7 page 1 erased");
    readChk(2, "R7 other block kept");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule